// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

The bridge turns host accesses into single-dword accesses on an internal configuration-register bus. A host reaches the configuration space in one of two ways. The indirect way writes a 32-bit address word into an address port and then reads or writes a separate data port. The direct way uses a flat memory-mapped window whose offset is itself the address word. The address word carries an enable flag (bit 31), a bus number (bits 23:16), a device number (bits 15:11), a function number (bits 10:8) and a register offset (bits 7:0).

Each request is decoded to a bus, device, function and dword-aligned register with a byte-enable mask. The bridge then checks that the target is present: the bus matches `bus_id`, the function is 0, and the device's bit in `dev_present` is set. Only then is a downstream access issued. The two paths treat unaligned accesses differently. The data port clips the length at the dword boundary. The memory window drops any access that would cross it. Reads from an absent target return all-ones bytes.

A controller built around a state machine handles one request at a time. The states are IDLE, DECODE, ACCESS and RESPOND, and they move in a fixed ring:

- ACCEPT: IDLE to DECODE when `hreq_valid` is seen.
- DECODED: DECODE to ACCESS.
- ISSUED: ACCESS to RESPOND.
- DONE: RESPOND to IDLE.

Every request therefore takes the same number of cycles.

Top module: `cfg_bridge`

## Requirements
- R1: `hreq_ready` is high only in IDLE. A request accepted at clock edge E0 gives `hrsp_valid` high for exactly one cycle, between edges E2 and E3, and `hreq_ready` is high again after E3.
- R2: Address port (`hreq_kind`=0): with k = `hreq_off[1:0]`, a write stores byte j of `hreq_wdata` (bits 8j+7:8j) into byte k+j of the address word, and a read returns byte k+j in response byte j. Bytes beyond the word end are not touched, and unused response bytes are 0. The address word resets to 0.
- R3: Data port (`hreq_kind`=1): the access goes to `cfg_dev` = word[15:11] and `cfg_reg` = word[7:0] with bits 1:0 cleared. `cfg_be` starts at lane k = `hreq_off[1:0]`, and `cfg_wdata` carries write byte j on lane k+j, with the other lanes zero.
- R4: On the data port the length is clipped to 4-k bytes, so `cfg_be` never reaches beyond lane 3 and the read response holds only the clipped bytes.
- R5: Memory window (`hreq_kind`=2): `hreq_off` is used directly as the address word with the enable bit forced to 1. Such accesses leave the address-port word unchanged.
- R6: A memory-window access with k+len > 4 causes no downstream access. Its read response is 0.
- R7: A downstream access is issued only when word[23:16] equals `bus_id`, word[10:8] is 0 and `dev_present[word[15:11]]` is 1.
- R8: A read of an absent target returns 8'hFF in each requested (clipped) byte and 0 above them. A write to an absent target issues nothing.
- R9: `cfg_valid` is high for a single cycle per request, in ACCESS, with `cfg_reg[1:0]`=0 and a nonzero, contiguous `cfg_be`.
- R10: The read response takes `cfg_rdata` from the ACCESS cycle, shifts it down by k bytes and keeps only the requested bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_id | input | 8 | Bus number this bridge serves |
| dev_present | input | 32 | One bit per device number, set when that device exists |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Bridge can accept a request |
| hreq_kind | input | 2 | 0 address port, 1 data port, 2 memory window |
| hreq_off | input | 24 | Offset within the port or window |
| hreq_len | input | 3 | Access length in bytes |
| hreq_we | input | 1 | 1 for write |
| hreq_wdata | input | 32 | Write bytes, first byte in bits 7:0 |
| hrsp_valid | output | 1 | Response pulse |
| hrsp_rdata | output | 32 | Read bytes, first byte in bits 7:0 |
| cfg_valid | output | 1 | Downstream access strobe |
| cfg_we | output | 1 | Downstream write |
| cfg_dev | output | 5 | Target device number |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_be | output | 4 | Byte-lane enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Lane-aligned read data, sampled in the strobe cycle |

## Verification
A request accepted at edge E0 updates the address word at E1. Its downstream strobe is driven between E1 and E2, and its response is valid between E2 and E3. The bench drives each request on a falling edge and counts three rising edges. It then samples the response on the following falling edge. Downstream strobes are logged at the rising edge that ends ACCESS, so the count and fields for a request are compared at the same falling edge as its response.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

    typedef enum logic [1:0] {
        KIND_ADDR = 2'd0,
        KIND_DATA = 2'd1,
        KIND_MEM  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DECODE  = 2'd1,
        ST_ACCESS  = 2'd2,
        ST_RESPOND = 2'd3
    } br_state_e;

    // Mask of the n lowest byte lanes (n saturates at 4).
    function automatic logic [3:0] low_lanes(input logic [2:0] n);
        logic [3:0] m;
        case (n)
            3'd0:    m = 4'b0000;
            3'd1:    m = 4'b0001;
            3'd2:    m = 4'b0011;
            3'd3:    m = 4'b0111;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] lanes_to_bits(input logic [3:0] m);
        logic [31:0] b;
        for (int i = 0; i < 4; i++) begin
            b[8*i +: 8] = {8{m[i]}};
        end
        return b;
    endfunction

endpackage

// File: rtl/cfg_bridge_ctrl.sv
module cfg_bridge_ctrl
    import cfg_bridge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output br_state_e state,
    output logic      ready,
    output logic      in_decode,
    output logic      in_access,
    output logic      in_respond
);
    br_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_DECODE;
            ST_DECODE:  nxt = ST_ACCESS;
            ST_ACCESS:  nxt = ST_RESPOND;
            ST_RESPOND: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        ready      = (state == ST_IDLE);
        in_decode  = (state == ST_DECODE);
        in_access  = (state == ST_ACCESS);
        in_respond = (state == ST_RESPOND);
    end
endmodule

// File: rtl/cfg_bridge_addr_latch.sv
module cfg_bridge_addr_latch #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LANES-1:0]   lane_we,
    input  logic [8*LANES-1:0] lane_data,
    output logic [8*LANES-1:0] word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word[8*i +: 8] <= 8'h00;
            else if (wr_en && lane_we[i])
                word[8*i +: 8] <= lane_data[8*i +: 8];
        end
    end
endmodule

// File: rtl/cfg_bridge_decode.sv
module cfg_bridge_decode
    import cfg_bridge_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5,
    parameter int FN_W  = 3,
    parameter int REG_W = 8,
    parameter int WIN_W = REG_W + FN_W + DEV_W + BUS_W,
    parameter int NDEV  = 1 << DEV_W
) (
    input  logic [1:0]       kind,
    input  logic [WIN_W-1:0] off,
    input  logic [2:0]       len,
    input  logic             we,
    input  logic [31:0]      wdata,
    input  logic [31:0]      word,
    input  logic [BUS_W-1:0] bus_id,
    input  logic [NDEV-1:0]  dev_present,
    output logic [3:0]       latch_be,
    output logic [31:0]      lane_wdata,
    output logic             go,
    output logic [DEV_W-1:0] dev,
    output logic [REG_W-1:0] reg_dw,
    output logic [3:0]       be,
    output logic [1:0]       k,
    output logic [3:0]       rmask,
    output logic             fill_ones,
    output logic [31:0]      port_rdata
);
    localparam int FN_LSB  = REG_W;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;
    localparam int EN_BIT  = 31;

    logic [2:0]       room, len_eff;
    logic [3:0]       span, amask;
    logic             crosses, present, to_target, is_addr;
    logic [31:0]      eff_word;
    logic [BUS_W-1:0] t_bus;
    logic [FN_W-1:0]  t_fn;
    logic [REG_W-1:0] t_reg;
    logic             unused_word_bits;

    always_comb begin
        k        = off[1:0];
        room     = 3'd4 - {1'b0, k};
        len_eff  = (len > room) ? room : len;
        span     = {2'b00, k} + {1'b0, len};
        crosses  = (span > 4'd4);
        is_addr  = (kind == KIND_ADDR);

        eff_word = word;
        if (kind == KIND_MEM) begin
            eff_word          = 32'(off);
            eff_word[EN_BIT]  = 1'b1;
        end

        t_bus    = eff_word[BUS_LSB +: BUS_W];
        dev      = eff_word[DEV_LSB +: DEV_W];
        t_fn     = eff_word[FN_LSB +: FN_W];
        t_reg    = eff_word[REG_W-1:0];
        reg_dw   = t_reg & ~REG_W'(3);
        present  = (t_bus == bus_id) && (t_fn == '0) && dev_present[dev];

        amask      = low_lanes(len_eff);
        be         = amask << k;
        lane_wdata = (wdata << {k, 3'b000}) & lanes_to_bits(be);
        to_target  = (kind == KIND_DATA) || ((kind == KIND_MEM) && !crosses);

        go         = to_target && present && (amask != 4'b0000);
        fill_ones  = to_target && !present && !we;
        rmask      = (!we && (to_target || is_addr)) ? amask : 4'b0000;
        latch_be   = (is_addr && we) ? be : 4'b0000;
        port_rdata = (is_addr && !we)
                   ? ((word >> {k, 3'b000}) & lanes_to_bits(amask)) : 32'h0;
    end

    assign unused_word_bits = ^eff_word[31:BUS_LSB + BUS_W];
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
    import cfg_bridge_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5,
    parameter int FN_W  = 3,
    parameter int REG_W = 8,
    parameter int WIN_W = REG_W + FN_W + DEV_W + BUS_W,
    parameter int NDEV  = 1 << DEV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_id,
    input  logic [NDEV-1:0]  dev_present,
    input  logic             hreq_valid,
    output logic             hreq_ready,
    input  logic [1:0]       hreq_kind,
    input  logic [WIN_W-1:0] hreq_off,
    input  logic [2:0]       hreq_len,
    input  logic             hreq_we,
    input  logic [31:0]      hreq_wdata,
    output logic             hrsp_valid,
    output logic [31:0]      hrsp_rdata,
    output logic             cfg_valid,
    output logic             cfg_we,
    output logic [DEV_W-1:0] cfg_dev,
    output logic [REG_W-1:0] cfg_reg,
    output logic [3:0]       cfg_be,
    output logic [31:0]      cfg_wdata,
    input  logic [31:0]      cfg_rdata
);
    br_state_e state;
    logic in_decode, in_access, in_respond, accept;

    // captured request
    logic [1:0]       q_kind;
    logic [WIN_W-1:0] q_off;
    logic [2:0]       q_len;
    logic             q_we;
    logic [31:0]      q_wdata;

    // decode results
    logic [3:0]       d_latch_be, d_be, d_rmask;
    logic [31:0]      d_lane_wdata, d_port_rdata, addr_word;
    logic             d_go, d_fill;
    logic [DEV_W-1:0] d_dev;
    logic [REG_W-1:0] d_reg;
    logic [1:0]       d_k;

    // registered access
    logic             a_go, a_fill;
    logic [1:0]       a_k;
    logic [3:0]       a_rmask;
    logic [31:0]      a_port;
    logic [31:0]      rsp_d;

    assign accept = hreq_valid && hreq_ready;

    cfg_bridge_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (hreq_valid),
        .state      (state),
        .ready      (hreq_ready),
        .in_decode  (in_decode),
        .in_access  (in_access),
        .in_respond (in_respond)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_kind  <= KIND_ADDR;
            q_off   <= '0;
            q_len   <= '0;
            q_we    <= 1'b0;
            q_wdata <= '0;
        end else if (accept) begin
            q_kind  <= hreq_kind;
            q_off   <= hreq_off;
            q_len   <= hreq_len;
            q_we    <= hreq_we;
            q_wdata <= hreq_wdata;
        end
    end

    cfg_bridge_decode #(
        .BUS_W (BUS_W), .DEV_W (DEV_W), .FN_W (FN_W),
        .REG_W (REG_W), .WIN_W (WIN_W), .NDEV (NDEV)
    ) u_decode (
        .kind        (q_kind),
        .off         (q_off),
        .len         (q_len),
        .we          (q_we),
        .wdata       (q_wdata),
        .word        (addr_word),
        .bus_id      (bus_id),
        .dev_present (dev_present),
        .latch_be    (d_latch_be),
        .lane_wdata  (d_lane_wdata),
        .go          (d_go),
        .dev         (d_dev),
        .reg_dw      (d_reg),
        .be          (d_be),
        .k           (d_k),
        .rmask       (d_rmask),
        .fill_ones   (d_fill),
        .port_rdata  (d_port_rdata)
    );

    cfg_bridge_addr_latch #(.LANES(4)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_decode),
        .lane_we   (d_latch_be),
        .lane_data (d_lane_wdata),
        .word      (addr_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_go      <= 1'b0;
            a_fill    <= 1'b0;
            a_k       <= '0;
            a_rmask   <= '0;
            a_port    <= '0;
            cfg_we    <= 1'b0;
            cfg_dev   <= '0;
            cfg_reg   <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
        end else if (in_decode) begin
            a_go      <= d_go;
            a_fill    <= d_fill;
            a_k       <= d_k;
            a_rmask   <= d_rmask;
            a_port    <= d_port_rdata;
            cfg_we    <= q_we;
            cfg_dev   <= d_dev;
            cfg_reg   <= d_reg;
            cfg_be    <= d_be;
            cfg_wdata <= d_lane_wdata;
        end
    end

    assign cfg_valid = in_access && a_go;

    always_comb begin
        rsp_d = a_port;
        if (a_go && !cfg_we)
            rsp_d = (cfg_rdata >> {a_k, 3'b000}) & lanes_to_bits(a_rmask);
        else if (a_fill)
            rsp_d = lanes_to_bits(a_rmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hrsp_rdata <= '0;
        else if (in_access) hrsp_rdata <= rsp_d;
    end

    assign hrsp_valid = in_respond;
endmodule

// File: rtl/cfg_bridge_checker.sv
module cfg_bridge_checker #(
    parameter int DEV_W = 5,
    parameter int REG_W = 8,
    parameter int NDEV  = 1 << DEV_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hreq_valid,
    input logic             hreq_ready,
    input logic             hrsp_valid,
    input logic             cfg_valid,
    input logic [DEV_W-1:0] cfg_dev,
    input logic [REG_W-1:0] cfg_reg,
    input logic [3:0]       cfg_be,
    input logic [NDEV-1:0]  dev_present
);
    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_valid && hreq_ready |=> !hreq_ready);

    p_reopen_after_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hrsp_valid |=> hreq_ready && !hrsp_valid);

    p_access_then_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> hrsp_valid);

    p_present_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> dev_present[cfg_dev]);

    p_aligned_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_reg & REG_W'(3)) == '0);

    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);

    p_contig_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_be inside {4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b0010,
                                     4'b0110, 4'b1110, 4'b0100, 4'b1100, 4'b1000});
endmodule

bind cfg_bridge cfg_bridge_checker #(
    .DEV_W (DEV_W), .REG_W (REG_W), .NDEV (NDEV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hreq_valid  (hreq_valid),
    .hreq_ready  (hreq_ready),
    .hrsp_valid  (hrsp_valid),
    .cfg_valid   (cfg_valid),
    .cfg_dev     (cfg_dev),
    .cfg_reg     (cfg_reg),
    .cfg_be      (cfg_be),
    .dev_present (dev_present)
);

// File: tb/cfg_bridge_test.sv
module cfg_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_id = 8'h01;
    logic [31:0] dev_present = 32'h0000_0088;
    logic        hreq_valid = 1'b0;
    logic        hreq_ready;
    logic [1:0]  hreq_kind = 2'd0;
    logic [23:0] hreq_off = '0;
    logic [2:0]  hreq_len = '0;
    logic        hreq_we = 1'b0;
    logic [31:0] hreq_wdata = '0;
    logic        hrsp_valid;
    logic [31:0] hrsp_rdata;
    logic        cfg_valid, cfg_we;
    logic [4:0]  cfg_dev;
    logic [7:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata;

    int n_chk = 0, n_fail = 0, ds_cnt = 0;
    logic [3:0]  ds_be;
    logic [31:0] ds_wdata;
    logic [4:0]  ds_dev;
    logic [7:0]  ds_reg;
    logic        ds_we;

    always #2.5 clk = ~clk;

    cfg_bridge uut (
        .clk (clk), .rst_n (rst_n), .bus_id (bus_id), .dev_present (dev_present),
        .hreq_valid (hreq_valid), .hreq_ready (hreq_ready), .hreq_kind (hreq_kind),
        .hreq_off (hreq_off), .hreq_len (hreq_len), .hreq_we (hreq_we),
        .hreq_wdata (hreq_wdata), .hrsp_valid (hrsp_valid), .hrsp_rdata (hrsp_rdata),
        .cfg_valid (cfg_valid), .cfg_we (cfg_we), .cfg_dev (cfg_dev), .cfg_reg (cfg_reg),
        .cfg_be (cfg_be), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata)
    );

    function automatic logic [31:0] tgt(input logic [4:0] d, input logic [7:0] r);
        return {r ^ 8'h5A, 3'b000, d, r, 8'hC3};
    endfunction
    assign cfg_rdata = tgt(cfg_dev, cfg_reg);

    always @(posedge clk) begin
        if (cfg_valid) begin
            ds_cnt   = ds_cnt + 1;
            ds_be    = cfg_be;
            ds_wdata = cfg_wdata;
            ds_dev   = cfg_dev;
            ds_reg   = cfg_reg;
            ds_we    = cfg_we;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [31:0] rd;
    logic        rv, busy_seen;

    task automatic xfer(input logic [1:0] kind, input logic [23:0] off,
                        input logic [2:0] len, input logic we, input logic [31:0] wd);
        @(negedge clk);
        hreq_valid = 1'b1; hreq_kind = kind; hreq_off = off;
        hreq_len = len; hreq_we = we; hreq_wdata = wd;
        @(posedge clk);              // E0 accept
        @(negedge clk);
        hreq_valid = 1'b0;
        busy_seen = !hreq_ready;
        @(posedge clk);              // E1
        @(posedge clk);              // E2
        @(negedge clk);
        rv = hrsp_valid;
        rd = hrsp_rdata;
        @(posedge clk);              // E3
        @(negedge clk);
        chk("R1 ready again", {31'b0, hreq_ready}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 ready at reset", {31'b0, hreq_ready}, 32'd1);
        chk("R9 no strobe at reset", {31'b0, cfg_valid}, 32'd0);
        xfer(2'd0, 24'h0, 3'd4, 1'b0, 32'h0);
        chk("R2 address word resets to 0", rd, 32'h0);
        chk("R1 busy after accept", {31'b0, busy_seen}, 32'd1);
        chk("R1 response due at E2..E3", {31'b0, rv}, 32'd1);
    endtask

    task automatic t_addr_port;
        xfer(2'd0, 24'h0, 3'd4, 1'b1, 32'h8001_1810);
        xfer(2'd0, 24'h0, 3'd4, 1'b0, 32'h0);
        chk("R2 full word readback", rd, 32'h8001_1810);
        xfer(2'd0, 24'h2, 3'd1, 1'b1, 32'h0000_0002);
        xfer(2'd0, 24'h2, 3'd2, 1'b0, 32'h0);
        chk("R2 byte write lane 2 readback", rd, 32'h0000_8002);
        xfer(2'd0, 24'h3, 3'd4, 1'b0, 32'h0);
        chk("R2 read clipped at word end", rd, 32'h0000_0080);
        xfer(2'd0, 24'h2, 3'd1, 1'b1, 32'h0000_0001);
        xfer(2'd0, 24'h0, 3'd4, 1'b0, 32'h0);
        chk("R2 restore bus byte", rd, 32'h8001_1810);
    endtask

    task automatic t_data_port;
        int c0;
        c0 = ds_cnt;
        xfer(2'd1, 24'h0, 3'd4, 1'b0, 32'h0);
        chk("R10 dword read data", rd, tgt(5'd3, 8'h10));
        chk("R3 one strobe", ds_cnt - c0, 32'd1);
        chk("R3 device", {27'b0, ds_dev}, 32'd3);
        chk("R3 register", {24'b0, ds_reg}, 32'h10);
        chk("R3 full be", {28'b0, ds_be}, 32'hF);
        xfer(2'd1, 24'h2, 3'd4, 1'b0, 32'h0);
        chk("R4 clipped be", {28'b0, ds_be}, 32'hC);
        chk("R4 R10 clipped read data", rd, 32'h0000_4A03);
        xfer(2'd1, 24'h1, 3'd2, 1'b1, 32'hFFFF_BEEF);
        chk("R3 write be", {28'b0, ds_be}, 32'h6);
        chk("R3 write lanes", ds_wdata, 32'h00BE_EF00);
        chk("R3 write flag", {31'b0, ds_we}, 32'd1);
        chk("R3 write response 0", rd, 32'h0);
    endtask

    task automatic t_absent;
        int c0;
        c0 = ds_cnt;
        xfer(2'd0, 24'h0, 3'd4, 1'b1, 32'h8001_2010);  // device 4, absent
        xfer(2'd1, 24'h1, 3'd2, 1'b0, 32'h0);
        chk("R8 absent read ones", rd, 32'h0000_FFFF);
        xfer(2'd1, 24'h0, 3'd4, 1'b1, 32'h1234_5678);
        chk("R8 absent write discarded", ds_cnt - c0, 32'd0);
        xfer(2'd0, 24'h0, 3'd4, 1'b1, 32'h8001_1910);  // device 3 function 1
        xfer(2'd1, 24'h0, 3'd4, 1'b0, 32'h0);
        chk("R7 nonzero function absent", rd, 32'hFFFF_FFFF);
        xfer(2'd0, 24'h0, 3'd4, 1'b1, 32'h8002_1810);  // bus 2
        xfer(2'd1, 24'h0, 3'd1, 1'b0, 32'h0);
        chk("R7 bus mismatch absent", rd, 32'h0000_00FF);
        chk("R7 no strobe to absent", ds_cnt - c0, 32'd0);
    endtask

    task automatic t_mem;
        int c0;
        xfer(2'd0, 24'h0, 3'd4, 1'b1, 32'h0000_0000);
        xfer(2'd2, 24'h01_3824, 3'd4, 1'b0, 32'h0);
        chk("R5 window read", rd, tgt(5'd7, 8'h24));
        chk("R5 window device", {27'b0, ds_dev}, 32'd7);
        xfer(2'd2, 24'h01_3826, 3'd2, 1'b0, 32'h0);
        chk("R5 R10 window upper half", rd, 32'h0000_7E07);
        chk("R5 window be", {28'b0, ds_be}, 32'hC);
        xfer(2'd0, 24'h0, 3'd4, 1'b0, 32'h0);
        chk("R5 address word untouched", rd, 32'h0);
        c0 = ds_cnt;
        xfer(2'd2, 24'h01_3827, 3'd2, 1'b0, 32'h0);
        chk("R6 crossing read returns 0", rd, 32'h0);
        xfer(2'd2, 24'h01_3825, 3'd4, 1'b1, 32'hCAFE_F00D);
        chk("R6 crossing accesses dropped", ds_cnt - c0, 32'd0);
        xfer(2'd2, 24'h01_2024, 3'd4, 1'b0, 32'h0);
        chk("R8 window absent read ones", rd, 32'hFFFF_FFFF);
    endtask

    bit done = 1'b0;
    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_port();
        t_data_port();
        t_absent();
        t_mem();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule